// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches a composite sync stream that an upstream slicer has already turned into a clean logic level (low during sync), sampled once per system clock. It sorts every low pulse by width into narrow pulses (line and equalizing pulses), broad pulses (the serrated vertical pulses) and solid pulses (a vertical interval with no serrations). From that it produces an active-low vertical sync pulse, a field flag for interlaced input, and a flag that tells whether the last vertical pulse came from the timed fallback path.

The serrated vertical pulse starts at the end of the first broad pulse and ends at the end of the first narrow pulse that follows. If the input holds low long enough to be a solid pulse, a vertical pulse of fixed length is produced instead. The field is judged from the distance between the falling edge of the first broad pulse and the falling edge of the low pulse just before it. A whole line gives the odd field. A shorter spacing gives the even field. All thresholds are parameters counted in clock cycles, so one netlist serves any scan rate. A short-pulse filter at the input removes noise spikes before any edge is seen.

Top module: `vsync_field_detect`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `vsync_n` is 1, `field_odd` is 0 and `default_used` is 0.
- R2: A low or high excursion on `csync_n` lasting fewer than GLITCH_MIN samples has no effect: it neither ends a vertical pulse nor shifts the field decision. An excursion of exactly GLITCH_MIN samples is accepted.
- R3: A low pulse of W samples is narrow when W <= BROAD_MIN, broad when BROAD_MIN < W < SOLID_MIN, and solid when W >= SOLID_MIN. A narrow pulse never starts a vertical pulse.
- R4: When idle, the end of a broad pulse drives `vsync_n` to 0 on the (GLITCH_MIN+1)-th clock edge after the first edge that samples `csync_n` high.
- R5: Once a serrated vertical pulse is active, further broad pulses keep it low, and the end of the first narrow pulse returns `vsync_n` to 1 with the same latency as R4.
- R6: `field_odd` changes only on the cycle where `vsync_n` falls for a serrated pulse. It becomes 1 when the fall-to-fall spacing from the previous low pulse to the first broad pulse is at least FULL_MIN samples, and 0 otherwise.
- R7: A solid pulse drives `vsync_n` to 0 on the (GLITCH_MIN+SOLID_MIN)-th edge after the first edge that samples `csync_n` low, and holds it low for exactly DEF_LEN cycles. `field_odd` is unchanged, and input pulses during that time are ignored.
- R8: `default_used` goes to 1 when a fallback pulse starts and to 0 when a serrated pulse starts. It changes at no other time.
- R9: The end of a solid pulse does not start a vertical pulse, even when it arrives after the fallback pulse has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_n | input | 1 | Sliced composite sync, low during sync |
| vsync_n | output | 1 | Vertical sync, active low, registered |
| field_odd | output | 1 | 1 for odd field, 0 for even field |
| default_used | output | 1 | 1 when the last vertical pulse came from the fallback timer |

## Verification
Every output moves a fixed number of edges after the stimulus that causes it. A pulse end shows on `vsync_n` GLITCH_MIN+1 edges after the first high sample. A fallback start shows GLITCH_MIN+SOLID_MIN edges after the first low sample, and it lasts DEF_LEN cycles. The bench drives `csync_n` on falling clock edges and logs the edge index at which each pulse starts and ends. It records the three outputs once per cycle, between edges, in a per-cycle log. Each check reads that log on the edge just before the predicted change and on the edge of the change. Where nothing may move, such as a rejected glitch or a narrow or solid pulse end, it checks the whole window.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  typedef enum logic [1:0] {
    VS_IDLE = 2'd0,
    VS_SERR = 2'd1,
    VS_DFLT = 2'd2
  } vfd_state_e;

  typedef struct packed {
    logic broad_end;
    logic narrow_end;
    logic solid_hit;
    logic odd_gap;
  } vfd_evt_t;

endpackage

// File: rtl/vfd_deglitch.sv
module vfd_deglitch #(
  parameter int unsigned GLITCH_MIN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned GW = (GLITCH_MIN < 2) ? 1 : $clog2(GLITCH_MIN + 1);
  localparam logic [GW-1:0] LIM = GW'(GLITCH_MIN - 1);

  logic          samp;
  logic          level;
  logic [GW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp  <= 1'b1;
      level <= 1'b1;
      run   <= '0;
    end else begin
      samp <= din;
      if (samp == level) begin
        run <= '0;
      end else if (run == LIM) begin
        level <= samp;
        run   <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  assign dout = level;
endmodule

// File: rtl/vfd_pulse_meter.sv
module vfd_pulse_meter
  import vfd_pkg::*;
#(
  parameter int unsigned BROAD_MIN = 8000,
  parameter int unsigned SOLID_MIN = 24000,
  parameter int unsigned FULL_MIN  = 12000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sync_lvl,
  output vfd_evt_t evt
);
  localparam int unsigned WW = $clog2(SOLID_MIN + 1);
  localparam int unsigned PW = $clog2(FULL_MIN + 1);
  localparam logic [WW-1:0] W_SAT   = WW'(SOLID_MIN);
  localparam logic [WW-1:0] W_BROAD = WW'(BROAD_MIN);
  localparam logic [WW-1:0] W_HIT   = WW'(SOLID_MIN - 1);
  localparam logic [PW-1:0] P_SAT   = PW'(FULL_MIN);

  logic          lvl_d;
  logic          fall, rise, low_run;
  logic [WW-1:0] width;
  logic [PW-1:0] since, spacing;

  assign fall    = lvl_d & ~sync_lvl;
  assign rise    = ~lvl_d & sync_lvl;
  assign low_run = ~lvl_d & ~sync_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d   <= 1'b1;
      width   <= '0;
      since   <= P_SAT;
      spacing <= P_SAT;
    end else begin
      lvl_d <= sync_lvl;
      if (fall) begin
        width <= WW'(1);
      end else if (!sync_lvl && width != W_SAT) begin
        width <= width + 1'b1;
      end
      if (fall) begin
        spacing <= since;
        since   <= PW'(1);
      end else if (since != P_SAT) begin
        since <= since + 1'b1;
      end
    end
  end

  always_comb begin
    evt.broad_end  = rise && (width > W_BROAD) && (width < W_SAT);
    evt.narrow_end = rise && (width <= W_BROAD);
    evt.solid_hit  = low_run && (width == W_HIT);
    evt.odd_gap    = (spacing >= P_SAT);
  end
endmodule

// File: rtl/vfd_vert_ctrl.sv
module vfd_vert_ctrl
  import vfd_pkg::*;
#(
  parameter int unsigned DEF_LEN = 9000
) (
  input  logic     clk,
  input  logic     rst,
  input  vfd_evt_t evt,
  output logic     vsync_n,
  output logic     field_odd,
  output logic     default_used
);
  localparam int unsigned DW = $clog2(DEF_LEN + 1);
  localparam logic [DW-1:0] D_LOAD = DW'(DEF_LEN - 1);

  vfd_state_e    state;
  logic [DW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= VS_IDLE;
      remain       <= '0;
      vsync_n      <= 1'b1;
      field_odd    <= 1'b0;
      default_used <= 1'b0;
    end else begin
      unique case (state)
        VS_IDLE: begin
          if (evt.broad_end) begin
            state        <= VS_SERR;
            vsync_n      <= 1'b0;
            field_odd    <= evt.odd_gap;
            default_used <= 1'b0;
          end else if (evt.solid_hit) begin
            state        <= VS_DFLT;
            vsync_n      <= 1'b0;
            remain       <= D_LOAD;
            default_used <= 1'b1;
          end
        end
        VS_SERR: begin
          if (evt.narrow_end) begin
            state   <= VS_IDLE;
            vsync_n <= 1'b1;
          end
        end
        VS_DFLT: begin
          if (remain == '0) begin
            state   <= VS_IDLE;
            vsync_n <= 1'b1;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        default: begin
          state   <= VS_IDLE;
          vsync_n <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/vsync_field_detect.sv
module vsync_field_detect
  import vfd_pkg::*;
#(
  parameter int unsigned GLITCH_MIN = 16,
  parameter int unsigned BROAD_MIN  = 8000,
  parameter int unsigned SOLID_MIN  = 24000,
  parameter int unsigned FULL_MIN   = 12000,
  parameter int unsigned DEF_LEN    = 9000
) (
  input  logic clk,
  input  logic rst,
  input  logic csync_n,
  output logic vsync_n,
  output logic field_odd,
  output logic default_used
);
  logic     clean_lvl;
  vfd_evt_t evt;

  vfd_deglitch #(.GLITCH_MIN(GLITCH_MIN)) u_deglitch (
    .clk  (clk),
    .rst  (rst),
    .din  (csync_n),
    .dout (clean_lvl)
  );

  vfd_pulse_meter #(
    .BROAD_MIN (BROAD_MIN),
    .SOLID_MIN (SOLID_MIN),
    .FULL_MIN  (FULL_MIN)
  ) u_meter (
    .clk      (clk),
    .rst      (rst),
    .sync_lvl (clean_lvl),
    .evt      (evt)
  );

  vfd_vert_ctrl #(.DEF_LEN(DEF_LEN)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .evt          (evt),
    .vsync_n      (vsync_n),
    .field_odd    (field_odd),
    .default_used (default_used)
  );
endmodule

// File: rtl/vfd_checker.sv
module vfd_checker #(
  parameter int unsigned DEF_LEN = 9000
) (
  input logic clk,
  input logic rst,
  input logic vsync_n,
  input logic field_odd,
  input logic default_used
);
  localparam int unsigned LW = $clog2(DEF_LEN + 2) + 1;
  localparam logic [LW-1:0] L_SAT = {LW{1'b1}};
  localparam logic [LW-1:0] L_DEF = LW'(DEF_LEN);

  logic [LW-1:0] low_len;

  always_ff @(posedge clk) begin
    if (rst) low_len <= '0;
    else if (!vsync_n && low_len != L_SAT) low_len <= low_len + 1'b1;
    else if (vsync_n) low_len <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (vsync_n && !field_odd && !default_used));

  p_field_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(field_odd) |-> $fell(vsync_n));

  p_fallback_len_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(vsync_n) && default_used) |-> (low_len == L_DEF));

  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(default_used) |-> $fell(vsync_n));

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(default_used) |-> $fell(vsync_n));
endmodule

bind vsync_field_detect vfd_checker #(.DEF_LEN(DEF_LEN)) u_vfd_checker (
  .clk          (clk),
  .rst          (rst),
  .vsync_n      (vsync_n),
  .field_odd    (field_odd),
  .default_used (default_used)
);

// File: tb/test_vsync_field_detect.sv
`timescale 1ns/1ps
module test_vsync_field_detect;
  localparam int G   = 3;
  localparam int BRD = 20;
  localparam int SLD = 60;
  localparam int FUL = 30;
  localparam int DEF = 25;
  localparam int LAT = G + 1;
  localparam int HN  = 16384;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync_n = 1'b1;
  logic vsync_n, field_odd, default_used;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_err = 0;
  int  last_fall, last_rise;
  bit  done = 1'b0;
  bit  hv [0:HN-1];
  bit  hf [0:HN-1];
  bit  hd [0:HN-1];

  vsync_field_detect #(
    .GLITCH_MIN (G), .BROAD_MIN (BRD), .SOLID_MIN (SLD),
    .FULL_MIN (FUL), .DEF_LEN (DEF)
  ) i_vsync_field_detect (
    .clk (clk), .rst (rst), .csync_n (csync_n),
    .vsync_n (vsync_n), .field_odd (field_odd), .default_used (default_used)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (cyc < HN) begin
    hv[cyc] = vsync_n; hf[cyc] = field_odd; hd[cyc] = default_used;
  end

  task automatic chk(input bit got, input bit exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic chk_hold(input int from, input int upto, input bit exp, input string tag);
    int bad = -1;
    for (int i = from; i <= upto; i++) if (hv[i] != exp && bad < 0) bad = i;
    n_chk++;
    if (bad >= 0) begin
      n_err++;
      $display("FAIL %s: vsync_n got %0b at cycle %0d expected %0b", tag, hv[bad], bad, exp);
    end
  endtask

  // low for lo samples, then high for hi samples; called right after a falling clock edge
  task automatic seg(input int lo, input int hi);
    csync_n = 1'b0; last_fall = cyc + 1;
    repeat (lo) @(negedge clk);
    csync_n = 1'b1; last_rise = cyc + 1;
    repeat (hi) @(negedge clk);
  endtask

  task automatic hlines(input int n);
    for (int i = 0; i < n; i++) seg(5, 35);
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    int rb, re, s, f;
    repeat (3) @(negedge clk);
    chk(vsync_n, 1'b1, "R1 vsync in reset");
    chk(field_odd, 1'b0, "R1 field in reset");
    chk(default_used, 1'b0, "R1 flag in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(vsync_n, 1'b1, "R1 vsync after reset");
    chk(field_odd, 1'b0, "R1 field after reset");

    // odd field: full-line spacing, glitch inside the active pulse
    hlines(4);
    seg(34, 6); rb = last_rise;
    for (int i = 0; i < 5; i++) seg(34, 6);
    seg(2, 18);
    seg(3, 17); re = last_rise;
    for (int i = 0; i < 5; i++) seg(3, 17);
    hlines(4);
    chk(hv[rb+LAT-1], 1'b1, "R4 odd before start");
    chk(hv[rb+LAT], 1'b0, "R4 odd start");
    chk(hf[rb+LAT], 1'b1, "R6 odd field");
    chk_hold(rb+LAT, re+LAT-1, 1'b0, "R5 R2 held through broads and glitch");
    chk(hv[re+LAT], 1'b1, "R5 odd end");

    // even field: half-line spacing before the first broad pulse
    hlines(3);
    seg(5, 15);
    seg(34, 6); rb = last_rise;
    for (int i = 0; i < 5; i++) seg(34, 6);
    seg(3, 17); re = last_rise;
    for (int i = 0; i < 5; i++) seg(3, 17);
    hlines(4);
    chk(hf[rb+LAT-1], 1'b1, "R6 field held before fall");
    chk(hf[rb+LAT], 1'b0, "R6 even field");
    chk(hv[re+LAT], 1'b1, "R5 even end");

    // odd field with a glitch that would shorten the spacing to 25
    hlines(3);
    seg(5, 10);
    seg(2, 23);
    seg(34, 6); rb = last_rise;
    for (int i = 0; i < 3; i++) seg(34, 6);
    seg(3, 17);
    hlines(3);
    chk(hf[rb+LAT], 1'b1, "R2 glitch ignored by field decision");

    // width boundaries: BRD is narrow, BRD+1 is broad
    hlines(2);
    seg(BRD, 40 - BRD); re = last_rise;
    chk_hold(re, re + 15, 1'b1, "R3 width BROAD_MIN is narrow");
    seg(BRD + 1, 39 - BRD); rb = last_rise;
    seg(BRD, 40 - BRD); re = last_rise;
    hlines(2);
    chk(hv[rb+LAT], 1'b0, "R3 width BROAD_MIN+1 starts");
    chk(hv[re+LAT-1], 1'b0, "R5 still low before narrow end");
    chk(hv[re+LAT], 1'b1, "R5 narrow pulse of BROAD_MIN ends");

    // fallback: long solid pulse
    hlines(4);
    seg(130, 10); f = last_fall; re = last_rise;
    hlines(3);
    s = f + G + SLD;
    chk(hv[s-1], 1'b1, "R7 before fallback");
    chk(hv[s], 1'b0, "R7 fallback start");
    chk(hd[s-1], 1'b0, "R8 flag before fallback");
    chk(hd[s], 1'b1, "R8 flag set");
    chk(hf[s], 1'b1, "R7 field unchanged");
    chk(hv[s+DEF-1], 1'b0, "R7 last low cycle");
    chk(hv[s+DEF], 1'b1, "R7 fallback end");
    chk_hold(s + DEF, re + 20, 1'b1, "R9 solid end ignored");

    // fallback at exactly SOLID_MIN, with a line pulse inside the fallback window
    hlines(2);
    seg(SLD, 20); f = last_fall;
    hlines(3);
    s = f + G + SLD;
    chk(hv[s], 1'b0, "R7 width SOLID_MIN takes fallback");
    chk_hold(s, s + DEF - 1, 1'b0, "R7 input ignored during fallback");
    chk(hv[s+DEF], 1'b1, "R7 boundary fallback end");

    // serrated pulse after fallback clears the flag
    hlines(2);
    seg(34, 6); rb = last_rise;
    seg(34, 6);
    chk(hd[rb+LAT-1], 1'b1, "R8 flag kept until serrated start");
    chk(hd[rb+LAT], 1'b0, "R8 flag cleared");
    chk(hv[rb+LAT], 1'b0, "R4 start after fallback");

    // reset while a serrated pulse is active
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(vsync_n, 1'b1, "R1 vsync on mid-run reset");
    chk(field_odd, 1'b0, "R1 field on mid-run reset");
    chk(default_used, 1'b0, "R1 flag on mid-run reset");
    rst = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule